// File: doc/BRIEF.md
# Wide-Immediate Instruction Decoder

This block decodes a stream of 64-bit virtual-machine instruction words. It takes one word per valid/ready handshake. It splits out the opcode byte, the destination and source register numbers, the signed offset and the signed 32-bit immediate. It also marks register numbers that lie out of range. It presents one registered result, which stays on the output until the consumer takes it.

One instruction, the wide-immediate load, spans two consecutive words. The decoder keeps the first word and waits for the second. It checks the second word as a pseudo slot and then emits a single result that carries the joined 64-bit constant. If the pseudo slot is malformed, the decoder drops the pair, pulses an error and returns to idle.

Word layout: opcode in bits 7:0, dst in 11:8, src in 15:12, offset in 31:16, imm in 63:32.

Top module: `wimm_decoder`

## Requirements
- R1: A word that is not a wide-immediate opcode, accepted while idle, gives `out_valid` one cycle later. The result carries opcode, dst, src and offset from the layout above, and `out_imm` is the imm field sign-extended to 64 bits. `out_wide` is 0.
- R2: For classes 4 to 7 (opcode bit 2 set), `out_src_reg` equals opcode bit 3: 0 selects the immediate and 1 selects the source register. For classes 0 to 3 it is 0.
- R3: `out_bad_reg` is 1 when dst exceeds 10. It is also 1 when src exceeds 10 and src is in use. Src is in use for classes 4 to 7 with opcode bit 3 set, and for classes 0 to 3 other than the wide opcode.
- R4: Accepting a wide-immediate word (opcode 0x18) while idle produces no output. The decoder enters a pending state and `in_ready` stays high.
- R5: In the pending state, a pseudo slot whose low 32 bits are all zero produces one result one cycle later. That result has `out_wide`=1 and the opcode, dst, src and offset of the first word. Its `out_imm` equals the first word's imm plus the pseudo imm shifted left by 32.
- R6: In a wide-immediate result, src is not checked as a register number. Only dst can set `out_bad_reg`.
- R7: The low 32 bits of a wide constant are taken unchanged from the first word and are not sign-extended into the upper half.
- R8: A pseudo slot with any non-zero bit in 31:0 pulses `err_pair` for exactly one cycle, one cycle after acceptance. It produces no result, and the next word is decoded from idle.
- R9: While `out_valid` is high and `out_ready` is low, the result holds steady and `in_ready` is low.
- R10: A synchronous reset clears `out_valid`, `err_pair` and any pending wide-immediate first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 64 | Instruction word |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result |
| out_opcode | output | 8 | Opcode byte |
| out_dst | output | 4 | Destination register number |
| out_src | output | 4 | Source field |
| out_off | output | 16 | Signed offset |
| out_imm | output | 64 | Immediate, sign-extended or joined wide value |
| out_src_reg | output | 1 | Operand comes from the source register |
| out_wide | output | 1 | Result is a joined wide-immediate |
| out_bad_reg | output | 1 | Register number out of range |
| err_pair | output | 1 | One-cycle pulse on a malformed pseudo slot |

## Verification
Every result and every `err_pair` pulse is due exactly one clock edge after the word that completes it is accepted. A wide first slot produces nothing at that edge. The bench drives inputs on falling edges. It holds `in_valid` across one rising edge and reads the outputs at the next falling edge, which is that one-edge latency. The hold test keeps `out_ready` low for several cycles before it releases the result. The malformed-pair test then checks that the pulse has cleared one cycle later.

// File: rtl/wimm_decoder.sv
module wimm_decoder #(
  parameter logic [7:0] WIDE_OP = 8'h18,
  parameter int unsigned MAX_REG = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_opcode,
  output logic [3:0]  out_dst,
  output logic [3:0]  out_src,
  output logic [15:0] out_off,
  output logic [63:0] out_imm,
  output logic        out_src_reg,
  output logic        out_wide,
  output logic        out_bad_reg,
  output logic        err_pair
);

  localparam logic [3:0] REG_LIM = 4'(MAX_REG);

  logic        pending;
  logic [63:0] first_w;

  wire        acc     = in_valid && in_ready;
  wire [7:0]  op      = in_word[7:0];
  wire [3:0]  dst     = in_word[11:8];
  wire [3:0]  src     = in_word[15:12];
  wire        is_wide = (op == WIDE_OP);
  wire        alu_jmp = op[2];
  wire        src_use = alu_jmp ? op[3] : !is_wide;
  wire        bad_now = (dst > REG_LIM) || (src_use && (src > REG_LIM));
  wire        pseudo_ok = (in_word[31:0] == 32'd0);
  wire        first_bad = (first_w[11:8] > REG_LIM);

  assign in_ready = !out_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      out_valid <= 1'b0;
      err_pair  <= 1'b0;
    end else begin
      err_pair <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (acc) begin
        if (pending) begin
          pending <= 1'b0;
          if (pseudo_ok) out_valid <= 1'b1;
          else           err_pair  <= 1'b1;
        end else if (is_wide) begin
          pending <= 1'b1;
        end else begin
          out_valid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc && !pending && is_wide) first_w <= in_word;
    if (acc) begin
      if (pending) begin
        out_opcode  <= first_w[7:0];
        out_dst     <= first_w[11:8];
        out_src     <= first_w[15:12];
        out_off     <= first_w[31:16];
        out_imm     <= {in_word[63:32], first_w[63:32]};
        out_src_reg <= 1'b0;
        out_wide    <= 1'b1;
        out_bad_reg <= first_bad;
      end else if (!is_wide) begin
        out_opcode  <= op;
        out_dst     <= dst;
        out_src     <= src;
        out_off     <= in_word[31:16];
        out_imm     <= {{32{in_word[63]}}, in_word[63:32]};
        out_src_reg <= alu_jmp && op[3];
        out_wide    <= 1'b0;
        out_bad_reg <= bad_now;
      end
    end
  end

endmodule

// File: rtl/wimm_decoder_chk.sv
module wimm_decoder_chk #(
  parameter logic [7:0] WIDE_OP = 8'h18
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_word,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_opcode,
  input logic [63:0] out_imm,
  input logic        out_wide,
  input logic        err_pair,
  input logic        pending
);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_imm) && $stable(out_opcode)));

  a_r9_no_accept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r4_pending: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !pending && in_word[7:0] == WIDE_OP) |=> (pending && !out_valid));

  a_r5_wide_op: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_wide) |-> (out_opcode == WIDE_OP));

  a_r8_no_out: assert property (@(posedge clk) disable iff (rst)
    err_pair |-> !out_valid);

  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    err_pair |=> !err_pair);

endmodule

bind wimm_decoder wimm_decoder_chk #(.WIDE_OP(WIDE_OP)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_opcode(out_opcode), .out_imm(out_imm), .out_wide(out_wide),
  .err_pair(err_pair), .pending(pending)
);

// File: tb/wimm_decoder_tb_top.sv
`timescale 1ns/1ps
module wimm_decoder_tb_top;
  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic [63:0] in_word = '0;
  logic out_ready = 0;
  logic in_ready, out_valid, out_src_reg, out_wide, out_bad_reg, err_pair;
  logic [7:0] out_opcode;
  logic [3:0] out_dst, out_src;
  logic [15:0] out_off;
  logic [63:0] out_imm;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wimm_decoder dut_i (.*);

  function automatic logic [63:0] mk(input logic [7:0] op, input logic [3:0] d,
      input logic [3:0] s, input logic [15:0] off, input logic [31:0] imm);
    return {imm, off, s, d, op};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_word = w; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic pop();
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic t_reset();
    chk("R10 reset out_valid", 64'(out_valid), 64'd0);
    chk("R10 reset in_ready", 64'(in_ready), 64'd1);
    chk("R10 reset err_pair", 64'(err_pair), 64'd0);
  endtask

  task automatic t_r1_plain();
    push(mk(8'h04, 4'd3, 4'd0, 16'hFFFE, 32'h8000_0001));
    chk("R1 valid", 64'(out_valid), 64'd1);
    chk("R1 fields", {out_opcode, out_dst, out_src, out_off}, {32'd0, 8'h04, 4'd3, 4'd0, 16'hFFFE});
    chk("R1 imm sext", out_imm, 64'hFFFF_FFFF_8000_0001);
    chk("R1 wide", 64'(out_wide), 64'd0);
    chk("R2 imm source", 64'(out_src_reg), 64'd0);
    pop();
  endtask

  task automatic t_r2_r3();
    push(mk(8'h0C, 4'd1, 4'd10, 16'd0, 32'd7));
    chk("R2 reg source", 64'(out_src_reg), 64'd1);
    chk("R3 src 10 ok", 64'(out_bad_reg), 64'd0);
    pop();
    push(mk(8'h0C, 4'd1, 4'd12, 16'd0, 32'd7));
    chk("R3 src 12 used", 64'(out_bad_reg), 64'd1);
    pop();
    push(mk(8'h04, 4'd1, 4'd15, 16'd0, 32'd7));
    chk("R3 src unused", 64'(out_bad_reg), 64'd0);
    pop();
    push(mk(8'h61, 4'd11, 4'd0, 16'd0, 32'd0));
    chk("R3 dst 11", 64'(out_bad_reg), 64'd1);
    chk("R2 low class", 64'(out_src_reg), 64'd0);
    pop();
  endtask

  task automatic t_wide();
    push(mk(8'h18, 4'd2, 4'd15, 16'h0005, 32'h1234_5678));
    chk("R4 no output", 64'(out_valid), 64'd0);
    chk("R4 ready", 64'(in_ready), 64'd1);
    push(mk(8'h00, 4'd0, 4'd0, 16'd0, 32'hCAFE_0001));
    chk("R5 valid", 64'(out_valid), 64'd1);
    chk("R5 imm", out_imm, 64'hCAFE_0001_1234_5678);
    chk("R5 fields", {out_opcode, out_dst, out_src, out_off, out_wide}, {8'h18, 4'd2, 4'd15, 16'h0005, 1'b1});
    chk("R6 src unchecked", 64'(out_bad_reg), 64'd0);
    pop();
    push(mk(8'h18, 4'd0, 4'd0, 16'd0, 32'hFFFF_FFFF));
    push(mk(8'h00, 4'd0, 4'd0, 16'd0, 32'h0));
    chk("R7 no sext", out_imm, 64'h0000_0000_FFFF_FFFF);
    pop();
  endtask

  task automatic t_r8_bad();
    push(mk(8'h18, 4'd1, 4'd0, 16'd0, 32'd9));
    push(mk(8'h00, 4'd0, 4'd0, 16'h0001, 32'd1));
    chk("R8 err pulse", 64'(err_pair), 64'd1);
    chk("R8 no out", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R8 pulse ends", 64'(err_pair), 64'd0);
    push(mk(8'h07, 4'd4, 4'd0, 16'd0, 32'd3));
    chk("R8 idle after", {out_valid, out_wide, out_opcode}, {55'd0, 1'b1, 1'b0, 8'h07});
    pop();
  endtask

  task automatic t_r9_hold();
    push(mk(8'h04, 4'd5, 4'd0, 16'd0, 32'd42));
    repeat (3) @(negedge clk);
    chk("R9 held valid", 64'(out_valid), 64'd1);
    chk("R9 held imm", out_imm, 64'd42);
    chk("R9 not ready", 64'(in_ready), 64'd0);
    pop();
    chk("R9 released", 64'(out_valid), 64'd0);
  endtask

  task automatic t_r10_reset_pending();
    push(mk(8'h18, 4'd1, 4'd0, 16'd0, 32'd1));
    rst = 1;
    @(negedge clk);
    rst = 0;
    push(mk(8'h18, 4'd3, 4'd0, 16'd0, 32'd5));
    chk("R10 pending cleared", 64'(out_valid), 64'd0);
    push(mk(8'h00, 4'd0, 4'd0, 16'd0, 32'd6));
    chk("R10 fresh pair", {out_dst, out_imm}, {4'd3, 64'h0000_0006_0000_0005});
    pop();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    t_reset();
    t_r1_plain();
    t_r2_r3();
    t_wide();
    t_r8_bad();
    t_r9_hold();
    t_r10_reset_pending();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule